// File: doc/BRIEF.md
# Arbitrating Wired-Bus Frame Transmitter

This block puts one frame at a time onto a shared single-wire bus. A driven 0 (dominant) overrides a released 1 (recessive), and every node may start a frame, so no node acts as master. A host hands over a frame with a valid/ready load handshake. The frame holds an 8-bit channel identifier, a 3-bit length code and a 64-bit payload word. The block then serialises the frame at a fixed number of clock cycles per bit and drives it onto the bus.

Arbitration happens on the identifier. While each identifier bit is on the bus, the block reads the bus back at the middle of the bit period. If the level seen differs from the level it drove, it releases the bus at once and flags the loss. It keeps the loaded frame and sends it again from the start bit once the bus has been quiet long enough.

Load handshake rules: `ld_ready` is high only while no frame is held, either waiting or in flight. A frame is taken on a clock edge where `ld_valid` and `ld_ready` are both high. While `ld_ready` is low the host must hold off. The block ignores anything presented during that time. There is no back-pressure on the bus side.

Top module: `wbus_frame_tx`

## Requirements
- R1: While no frame is in flight, `bus_tx` is 1 (recessive). Every frame opens with exactly one bit period of `bus_tx` = 0.
- R2: Bit periods 1 to 8 of a frame carry `ld_chan`, most significant bit first.
- R3: Bit period 9 is a dominant (0) continue bit. Bit periods 10 to 12 carry `ld_len`, most significant bit first.
- R4: After the length field come `ld_len`+1 payload bytes. Byte i is `ld_data[8i+7:8i]`, byte 0 goes first, and each byte is sent MSB first. One recessive stop bit follows. `busy` is high for exactly 14+8(`ld_len`+1) bit periods, each CYC_PER_BIT cycles long.
- R5: If the bus level sampled at mid-bit of an identifier bit differs from the bit driven, then from the next cycle `bus_tx` is 1 and `busy` is 0. `lost` pulses for one cycle and `retry_req` goes high.
- R6: After a loss, the same held frame is sent again in full, with no new load. `retry_req` is low again in the cycle its new start bit is driven.
- R7: A start bit is driven only after `bus_rx` has been 1 for at least IDLE_BITS×CYC_PER_BIT consecutive cycles, counted from reset or from the last dominant level.
- R8: `done` is a one-cycle pulse in the cycle after the last cycle of a successful stop bit. Each time `busy` falls, it is followed by exactly one of `done` or `lost`.
- R9: `ld_ready` is 1 after reset and after `done`, and 0 from the accepting edge until the frame completes. `ld_valid` has no effect while `ld_ready` is 0.
- R10: A mismatch between `bus_rx` and `bus_tx` outside the identifier bits does not abort the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Frame offered by host |
| ld_ready | output | 1 | Block can take a frame |
| ld_chan | input | 8 | Channel identifier |
| ld_len | input | 3 | Payload length code (bytes minus one) |
| ld_data | input | 64 | Payload, byte i in bits [8i+7:8i] |
| bus_rx | input | 1 | Bus level read back |
| bus_tx | output | 1 | Bus drive, 0 dominant, 1 released |
| busy | output | 1 | Frame being driven, start through stop |
| done | output | 1 | One-cycle pulse after a successful frame |
| lost | output | 1 | One-cycle pulse on lost arbitration |
| retry_req | output | 1 | Held frame waits for a retry |

## Verification
The embedded assertions check on every cycle that a frame opens dominant and only after the idle detector agreed. They also check that `done` and `lost` are single-cycle pulses, that each fall of `busy` is explained by one of them, that a loss leaves the bus released, and that the load handshake closes after acceptance. The bit-accurate layout of identifier, continue bit, length and payload can only be shown by the scenario bench, which compares every mid-bit sample of `bus_tx` against an expected stream. The same holds for the exact bit where arbitration is lost against a contending node, the full retransmission afterwards, and the immunity to payload collisions.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
  typedef enum logic [1:0] {
    WB_IDLE,
    WB_PEND,
    WB_SEND,
    WB_BACKOFF
  } wb_state_e;
endpackage

// File: rtl/wbt_bit_clock.sv
// Divides the clock into bit periods while a frame runs.
module wbt_bit_clock #(
  parameter int CYC_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mid,
  output logic bit_end
);
  localparam int CW  = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam int MID = CYC_PER_BIT / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                           cnt <= '0;
    else if (!run)                        cnt <= '0;
    else if (cnt == CW'(CYC_PER_BIT - 1)) cnt <= '0;
    else                                  cnt <= cnt + CW'(1);
  end

  assign mid     = run && (cnt == CW'(MID));
  assign bit_end = run && (cnt == CW'(CYC_PER_BIT - 1));
endmodule

// File: rtl/wbt_idle_watch.sv
// Flags the bus idle after a long enough unbroken recessive run.
module wbt_idle_watch #(
  parameter int CYC_PER_BIT = 16,
  parameter int IDLE_BITS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic idle
);
  localparam int THRESH = CYC_PER_BIT * IDLE_BITS;
  localparam int TW     = $clog2(THRESH + 1);

  logic [TW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                       run_len <= '0;
    else if (!rx)                     run_len <= '0;
    else if (run_len != TW'(THRESH))  run_len <= run_len + TW'(1);
  end

  assign idle = (run_len == TW'(THRESH));

  // R7
  idle_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> $past(rx));
endmodule

// File: rtl/wbt_frame_ser.sv
// Maps a bit index inside the frame to the level to drive.
module wbt_frame_ser #(
  parameter int ID_W  = 8,
  parameter int LEN_W = 3
) (
  input  logic [ID_W-1:0]                   chan,
  input  logic [LEN_W-1:0]                  len,
  input  logic [8*(1<<LEN_W)-1:0]           data,
  input  logic [$clog2(ID_W+LEN_W+3+8*(1<<LEN_W))-1:0] idx,
  output logic                              bit_o,
  output logic                              in_id,
  output logic                              at_stop
);
  localparam int NBYTES    = 1 << LEN_W;
  localparam int DATA_BASE = ID_W + LEN_W + 2;
  localparam int FRAME_W   = DATA_BASE + 8 * NBYTES + 1;
  localparam int IDX_W     = $clog2(FRAME_W);

  logic [FRAME_W-1:0] vec;
  logic [IDX_W-1:0]   stop_pos;

  assign vec[0]      = 1'b0;
  assign vec[ID_W+1] = 1'b0;
  assign vec[FRAME_W-1] = 1'b1;

  for (genvar gi = 0; gi < ID_W; gi++) begin : g_id
    assign vec[1+gi] = chan[ID_W-1-gi];
  end

  for (genvar gl = 0; gl < LEN_W; gl++) begin : g_len
    assign vec[ID_W+2+gl] = len[LEN_W-1-gl];
  end

  // Bytes past the coded length read as recessive, so the stop bit
  // falls out at the first unused slot.
  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    for (genvar gj = 0; gj < 8; gj++) begin : g_bit
      assign vec[DATA_BASE+8*gb+gj] =
        (gb <= int'(len)) ? data[8*gb+7-gj] : 1'b1;
    end
  end

  assign stop_pos = IDX_W'(DATA_BASE) + ((IDX_W'(len) + IDX_W'(1)) << 3);
  assign bit_o    = vec[idx];
  assign in_id    = (idx != '0) && (idx <= IDX_W'(ID_W));
  assign at_stop  = (idx == stop_pos);
endmodule

// File: rtl/wbus_frame_tx.sv
module wbus_frame_tx
  import wbt_pkg::*;
#(
  parameter int CYC_PER_BIT = 16,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = 8,
  parameter int LEN_W       = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_valid,
  output logic                        ld_ready,
  input  logic [ID_W-1:0]             ld_chan,
  input  logic [LEN_W-1:0]            ld_len,
  input  logic [8*(1<<LEN_W)-1:0]     ld_data,
  input  logic                        bus_rx,
  output logic                        bus_tx,
  output logic                        busy,
  output logic                        done,
  output logic                        lost,
  output logic                        retry_req
);
  localparam int NBYTES  = 1 << LEN_W;
  localparam int DATA_W  = 8 * NBYTES;
  localparam int FRAME_W = ID_W + LEN_W + 3 + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);

  wb_state_e          state;
  logic [IDX_W-1:0]   idx;
  logic [ID_W-1:0]    chan_q;
  logic [LEN_W-1:0]   len_q;
  logic [DATA_W-1:0]  data_q;
  logic               lost_q, done_q, retry_q;
  logic               rx_s, bus_idle, mid, bit_end;
  logic               bit_o, in_id, at_stop, mismatch;

  // Bus read-back synchroniser
  if (SYNC_STAGES == 0) begin : g_nosync
    assign rx_s = bus_rx;
  end else begin : g_sync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= (sh << 1) | SYNC_STAGES'(bus_rx);
    end
    assign rx_s = sh[SYNC_STAGES-1];
  end

  wbt_bit_clock #(.CYC_PER_BIT(CYC_PER_BIT)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(state == WB_SEND),
    .mid(mid), .bit_end(bit_end)
  );

  wbt_idle_watch #(.CYC_PER_BIT(CYC_PER_BIT), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .rx(rx_s), .idle(bus_idle)
  );

  wbt_frame_ser #(.ID_W(ID_W), .LEN_W(LEN_W)) u_ser (
    .chan(chan_q), .len(len_q), .data(data_q), .idx(idx),
    .bit_o(bit_o), .in_id(in_id), .at_stop(at_stop)
  );

  assign mismatch = mid && in_id && (rx_s != bit_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WB_IDLE;
      idx     <= '0;
      chan_q  <= '0;
      len_q   <= '0;
      data_q  <= '0;
      lost_q  <= 1'b0;
      done_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      lost_q <= 1'b0;
      done_q <= 1'b0;
      unique case (state)
        WB_IDLE: if (ld_valid) begin
          chan_q <= ld_chan;
          len_q  <= ld_len;
          data_q <= ld_data;
          state  <= WB_PEND;
        end
        WB_PEND, WB_BACKOFF: if (bus_idle) begin
          state   <= WB_SEND;
          idx     <= '0;
          retry_q <= 1'b0;
        end
        WB_SEND: begin
          if (mismatch) begin
            state   <= WB_BACKOFF;
            lost_q  <= 1'b1;
            retry_q <= 1'b1;
          end else if (bit_end) begin
            if (at_stop) begin
              state  <= WB_IDLE;
              done_q <= 1'b1;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: state <= WB_IDLE;
      endcase
    end
  end

  assign ld_ready  = (state == WB_IDLE);
  assign busy      = (state == WB_SEND);
  assign bus_tx    = (state == WB_SEND) ? bit_o : 1'b1;
  assign done      = done_q;
  assign lost      = lost_q;
  assign retry_req = retry_q;

  // R1
  start_dominant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !bus_tx);
  // R7
  start_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_idle));
  // R6
  retry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !retry_req);
  // R5
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (bus_tx && !busy && retry_req));
  // R5
  lost_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !lost);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done != lost));
  // R9
  accept_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);
endmodule

// File: tb/wbus_frame_tx_tb.sv
`timescale 1ns/1ps
module wbus_frame_tx_tb;
  localparam int CPB = 8;
  localparam int IDLE_BITS = 10;
  localparam int THRESH = CPB * IDLE_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        ld_valid = 1'b0;
  logic [7:0]  ld_chan = '0;
  logic [2:0]  ld_len = '0;
  logic [63:0] ld_data = '0;
  logic        cont_tx = 1'b1;
  logic        bus_rx, bus_tx, ld_ready, busy, done, lost, retry_req;

  assign bus_rx = bus_tx & cont_tx;

  wbus_frame_tx #(.CYC_PER_BIT(CPB), .IDLE_BITS(IDLE_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_chan(ld_chan), .ld_len(ld_len), .ld_data(ld_data),
    .bus_rx(bus_rx), .bus_tx(bus_tx), .busy(busy), .done(done),
    .lost(lost), .retry_req(retry_req)
  );

  int checks = 0, errors = 0;
  int done_cnt = 0, lost_cnt = 0, start_cnt = 0, hi_run = 0, bcnt = 0;
  logic prev_busy = 1'b0, prev_done = 1'b0;
  bit exp_q[$];
  bit finished = 1'b0;

  logic        cont_en = 1'b0;
  logic [7:0]  cont_id = '0;
  logic [2:0]  cont_len = '0;
  logic [63:0] cont_data = '0;

  task automatic chk(bit ok, string tag, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int frame_len(logic [2:0] len);
    return 14 + 8 * (int'(len) + 1);
  endfunction

  function automatic logic frame_bit(logic [7:0] id, logic [2:0] len,
                                     logic [63:0] d, int i);
    logic [7:0]  t;
    logic [2:0]  tl;
    logic [63:0] td;
    int k;
    if (i == 0) return 1'b0;
    if (i <= 8) begin t = id >> (8 - i); return t[0]; end
    if (i == 9) return 1'b0;
    if (i <= 12) begin tl = len >> (12 - i); return tl[0]; end
    k = i - 13;
    if (k < 8 * (int'(len) + 1)) begin
      td = d >> (8 * (k / 8) + 7 - (k % 8));
      return td[0];
    end
    return 1'b1;
  endfunction

  // Driver side of the scoreboard
  task automatic push_frame(logic [7:0] id, logic [2:0] len, logic [63:0] d, int upto);
    for (int i = 0; i < upto; i++) exp_q.push_back(frame_bit(id, len, d, i));
  endtask

  task automatic load(logic [7:0] id, logic [2:0] len, logic [63:0] d);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_chan = id; ld_len = len; ld_data = d; ld_valid = 1'b1;
    @(posedge clk);
    #1 ld_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: mid-bit comparison and pulse bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !prev_busy) begin
        start_cnt++;
        chk(hi_run >= THRESH, "R7", hi_run, THRESH, "recessive run before start");
        chk(!retry_req, "R6", retry_req, 0, "retry_req at start bit");
        bcnt = 0;
      end
      if (busy) begin
        if (bcnt % CPB == CPB / 2) begin
          int bn;
          string tag;
          bn = bcnt / CPB;
          if (bn == 0) tag = "R1";
          else if (bn <= 8) tag = "R2";
          else if (bn <= 12) tag = "R3";
          else tag = "R4";
          if (exp_q.size() == 0) chk(1'b0, "R4", bn, -1, "unexpected extra bit");
          else begin
            bit e;
            e = exp_q.pop_front();
            chk(bus_tx == e, tag, bus_tx, e, $sformatf("frame bit %0d", bn));
          end
        end
        bcnt++;
      end
      if (done) begin
        done_cnt++;
        chk(prev_busy && !busy, "R8", busy, 0, "done right after stop bit");
        chk(!prev_done, "R8", prev_done, 0, "done width");
      end
      if (lost) begin
        lost_cnt++;
        chk(retry_req && bus_tx && !busy, "R5", {retry_req, bus_tx, busy}, 3'b110,
            "state after loss");
      end
      hi_run = bus_rx ? hi_run + 1 : 0;
      prev_busy = busy;
      prev_done = done;
    end
  end

  // Contending node, aligned to the DUT's start bit
  initial begin
    forever begin
      @(posedge busy);
      if (cont_en) begin
        cont_en = 1'b0;
        for (int i = 0; i < frame_len(cont_len); i++) begin
          if (i == 0) @(negedge clk);
          else repeat (CPB) @(negedge clk);
          #1 cont_tx = frame_bit(cont_id, cont_len, cont_data, i);
        end
        repeat (CPB) @(negedge clk);
        #1 cont_tx = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", done_cnt, 6, "watchdog expired");
    summary();
  end

  initial begin
    int jlose;
    logic [7:0]  id_a;
    logic [63:0] pay_a;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(bus_tx == 1'b1, "R1", bus_tx, 1, "bus_tx in reset");
    chk(busy == 1'b0, "R4", busy, 0, "busy in reset");
    chk(done == 1'b0 && lost == 1'b0, "R8", {done, lost}, 0, "pulses in reset");
    chk(retry_req == 1'b0, "R6", retry_req, 0, "retry_req in reset");
    chk(ld_ready == 1'b1, "R9", ld_ready, 1, "ld_ready in reset");
    rst_n = 1'b1;

    // Typical frame
    push_frame(8'h5A, 3'd2, 64'h0000_0000_00C3_7E81, frame_len(3'd2));
    load(8'h5A, 3'd2, 64'h0000_0000_00C3_7E81);
    @(negedge clk);
    chk(ld_ready == 1'b0, "R9", ld_ready, 0, "ld_ready after accept");
    wait (done_cnt == 1);
    @(negedge clk);
    chk(ld_ready == 1'b1, "R9", ld_ready, 1, "ld_ready after done");

    // Shortest and longest payloads
    push_frame(8'hFF, 3'd0, 64'hFFFF_FFFF_FFFF_FFA5, frame_len(3'd0));
    load(8'hFF, 3'd0, 64'hFFFF_FFFF_FFFF_FFA5);
    wait (done_cnt == 2);
    push_frame(8'h00, 3'd7, 64'h0123_4567_89AB_CDEF, frame_len(3'd7));
    load(8'h00, 3'd7, 64'h0123_4567_89AB_CDEF);
    wait (done_cnt == 3);

    // Arbitration loss against a lower identifier, then retry
    id_a = 8'h93; pay_a = 64'h0000_0000_0000_5AA5;
    cont_id = 8'h91; cont_len = 3'd1; cont_data = 64'h0000_0000_0000_1234;
    jlose = 0;
    for (int i = 1; i <= 8; i++)
      if (jlose == 0 && frame_bit(id_a, 3'd1, pay_a, i) != frame_bit(cont_id, cont_len, cont_data, i))
        jlose = i;
    push_frame(id_a, 3'd1, pay_a, jlose + 1);
    push_frame(id_a, 3'd1, pay_a, frame_len(3'd1));
    cont_en = 1'b1;
    load(id_a, 3'd1, pay_a);
    wait (lost_cnt == 1);
    @(negedge clk);
    chk(ld_ready == 1'b0, "R6", ld_ready, 0, "frame still held after loss");
    wait (done_cnt == 4);
    chk(lost_cnt == 1, "R5", lost_cnt, 1, "one loss");
    chk(start_cnt == 5, "R6", start_cnt, 5, "retry started again");

    // Payload collision after a tied identifier must not abort
    cont_id = 8'h3C; cont_len = 3'd3; cont_data = 64'h0;
    push_frame(8'h3C, 3'd3, 64'hFFFF_FFFF_F0F0_FFFF, frame_len(3'd3));
    cont_en = 1'b1;
    load(8'h3C, 3'd3, 64'hFFFF_FFFF_F0F0_FFFF);
    wait (done_cnt == 5);
    chk(lost_cnt == 1, "R10", lost_cnt, 1, "no loss on payload collision");

    // Offer during a busy frame is ignored
    push_frame(8'h21, 3'd1, 64'h0000_0000_0000_BEEF, frame_len(3'd1));
    load(8'h21, 3'd1, 64'h0000_0000_0000_BEEF);
    wait (busy);
    @(negedge clk);
    ld_chan = 8'h77; ld_len = 3'd5; ld_data = 64'hDEAD_DEAD_DEAD_DEAD; ld_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ld_ready == 1'b0, "R9", ld_ready, 0, "ld_ready while busy");
    end
    ld_valid = 1'b0;
    wait (done_cnt == 6);
    repeat (40 * CPB) @(negedge clk);
    chk(start_cnt == 7, "R9", start_cnt, 7, "no frame from ignored offer");
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0, "expected bits left over");
    chk(done_cnt == 6, "R8", done_cnt, 6, "done count");
    summary();
  end
endmodule